// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out the two locked read-modify-write instructions of a 32-bit big-endian integer unit. The first is a full-word exchange and the second is a byte test-and-set. The integer unit hands over an operation, an address and a source register value. The block then runs one read and one write to the same address as an indivisible pair and returns either the old memory contents or a trap code.

During the read, the cache and memory see an ordinary load. The permission query sent to the MMU for that same read is marked as a store. As a result, a page that may be read but not written faults on the first access. The pipeline only inspects the first access of a multi-access instruction, so this is the only point where a fault can be caught. After such a fault the write is never issued and no register writeback is signalled, so the instruction can be restarted after the trap.

A bus lock covers the whole pair, so no other master can reach memory between the read and the write. A word exchange to an address that is not word-aligned traps immediately and touches neither the MMU nor memory.

Top module: `atomic_rmw_seq`

## Requirements
- R1: After reset, and while no request is in flight, `req_ready` is 1 and `mem_req_valid`, `mmu_chk_valid`, `mem_lock` and `rsp_valid` are 0.
- R2: A word exchange (`req_op`=0) reads the addressed word, then writes `req_src` to it with all byte enables set. It responds with `rsp_trap_code`=0, `rsp_rd_we`=1 and `rsp_rdata` equal to the old word.
- R3: A byte test-and-set (`req_op`=1) writes 8'hFF into the addressed byte only, with exactly one `mem_be` bit set. It returns the old byte zero-extended to 32 bits, with `rsp_rd_we`=1.
- R4: Byte lanes are big-endian. Address bits [1:0] equal to k select data bits [31-8k:24-8k], and `mem_be` bit i enables data bits [8i+7:8i]. Offset 0 therefore maps to `mem_be[3]` and offset 3 to `mem_be[0]`.
- R5: For both operations, the read phase drives `mem_req_write`=0 with all byte enables set. The concurrent MMU query carries `mmu_chk_write`=1.
- R6: When the MMU answers the query with a fault, the response has `rsp_trap_code`=1 (protection), `rsp_rd_we`=0 and `rsp_rdata`=0. No memory write is issued and memory is left unchanged.
- R7: A word exchange whose address bits [1:0] are nonzero responds with `rsp_trap_code`=2 (alignment) and `rsp_rd_we`=0. It makes no memory request and no MMU query. A test-and-set accepts any byte offset.
- R8: `mem_lock` rises together with the read request. It stays high on every cycle of the read and the write, including the write acknowledge, and it is low once the response is given.
- R9: `rsp_valid` is a one-cycle pulse. `req_ready` is 0 from acceptance until the response cycle ends.
- R10: The MMU answer and the memory read acknowledge may arrive in either order or in the same cycle. The write is issued only after both have been received and the answer was not a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request from the integer unit |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_op | input | 1 | 0 word exchange, 1 byte test-and-set |
| req_addr | input | AW | Byte address |
| req_src | input | DW | Source register value for the exchange |
| mmu_chk_valid | output | 1 | Permission query pending |
| mmu_chk_write | output | 1 | Query access type, 1 = store |
| mmu_chk_addr | output | AW | Address under query |
| mmu_rsp_valid | input | 1 | MMU answer strobe |
| mmu_rsp_fault | input | 1 | MMU answer: access not permitted |
| mem_req_valid | output | 1 | Memory request, held until acknowledged |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_lock | output | 1 | Bus lock across the pair |
| mem_addr | output | AW | Word address, low bits zero |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Byte enables |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Read data, valid with acknowledge |
| rsp_valid | output | 1 | Result strobe |
| rsp_trap_code | output | 2 | 0 none, 1 protection, 2 alignment |
| rsp_rd_we | output | 1 | Destination register write enable |
| rsp_rdata | output | DW | Old value for the destination register |

## Verification
The MMU answer and the memory read acknowledge can fall in the same clock edge, and a fault can land there too. The bench provokes this by giving its MMU and memory responders equal latencies. It also skews them in both directions so that each event arrives first in turn. Each case is judged at the ports against a reference memory. A faulting pair must leave memory unchanged, issue no write, report trap code 1 and not signal writeback. A clean pair must write once under lock and return the old value.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

   typedef enum logic [1:0] {
      TRAP_NONE  = 2'd0,
      TRAP_PROT  = 2'd1,
      TRAP_ALIGN = 2'd2
   } trap_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2,
      SEQ_RESP  = 2'd3
   } seq_state_e;

   localparam logic OP_XCHG_WORD = 1'b0;
   localparam logic OP_SET_BYTE  = 1'b1;

endpackage

// File: rtl/atomic_rmw_lanes.sv
module atomic_rmw_lanes
   import atomic_rmw_pkg::*;
#(
   parameter int       DW        = 32,
   parameter logic [7:0] SET_VALUE = 8'hFF,
   localparam int      LANES     = DW / 8,
   localparam int      OFS_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             op_byte,
   input  logic [OFS_W-1:0] offset,
   input  logic [DW-1:0]    src,
   input  logic [DW-1:0]    old_word,
   output logic [DW-1:0]    wr_data,
   output logic [LANES-1:0] wr_be,
   output logic [DW-1:0]    result
);

   logic [LANES-1:0] lane_hit;
   logic [7:0]       picked;

   // Big-endian lane map: offset 0 is the most significant lane.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_hit[g]          = (offset == OFS_W'(LANES - 1 - g));
      assign wr_data[g*8 +: 8]    = op_byte ? SET_VALUE : src[g*8 +: 8];
      assign wr_be[g]             = op_byte ? lane_hit[g] : 1'b1;
   end

   always_comb begin
      picked = '0;
      for (int i = 0; i < LANES; i++) begin
         if (lane_hit[i]) picked = picked | old_word[i*8 +: 8];
      end
   end

   assign result = op_byte ? {{(DW-8){1'b0}}, picked} : old_word;

endmodule

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl
   import atomic_rmw_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int OFS_W = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_src,
   output logic          mmu_chk_valid,
   output logic          mmu_chk_write,
   input  logic          mmu_rsp_valid,
   input  logic          mmu_rsp_fault,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic          mem_lock,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          rsp_valid,
   output trap_e         rsp_trap,
   output logic          op_q,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] src_q,
   output logic [DW-1:0] old_q
);

   seq_state_e state, state_nx;
   logic       rd_done, chk_done, fault_q;
   trap_e      trap_q;
   logic       misaligned;
   logic       rd_now, chk_now, fault_now, pair_done;

   // Alignment test only exists when a word spans more than one byte.
   if (OFS_W > 0) begin : g_align
      assign misaligned = (req_op == OP_XCHG_WORD) && (req_addr[OFS_W-1:0] != '0);
   end else begin : g_noalign
      assign misaligned = 1'b0;
   end

   assign rd_now    = rd_done  | mem_ack;
   assign chk_now   = chk_done | mmu_rsp_valid;
   assign fault_now = chk_done ? fault_q : mmu_rsp_fault;
   assign pair_done = rd_now && chk_now;

   always_comb begin
      state_nx = state;
      unique case (state)
         SEQ_IDLE:  if (req_valid) state_nx = misaligned ? SEQ_RESP : SEQ_READ;
         SEQ_READ:  if (pair_done) state_nx = fault_now ? SEQ_RESP : SEQ_WRITE;
         SEQ_WRITE: if (mem_ack)   state_nx = SEQ_RESP;
         SEQ_RESP:  state_nx = SEQ_IDLE;
         default:   state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         op_q     <= 1'b0;
         addr_q   <= '0;
         src_q    <= '0;
         old_q    <= '0;
         rd_done  <= 1'b0;
         chk_done <= 1'b0;
         fault_q  <= 1'b0;
         trap_q   <= TRAP_NONE;
      end else begin
         state <= state_nx;
         unique case (state)
            SEQ_IDLE: if (req_valid) begin
               op_q     <= req_op;
               addr_q   <= req_addr;
               src_q    <= req_src;
               rd_done  <= 1'b0;
               chk_done <= 1'b0;
               fault_q  <= 1'b0;
               trap_q   <= misaligned ? TRAP_ALIGN : TRAP_NONE;
            end
            SEQ_READ: begin
               if (mem_ack && !rd_done) begin
                  rd_done <= 1'b1;
                  old_q   <= mem_rdata;
               end
               if (mmu_rsp_valid && !chk_done) begin
                  chk_done <= 1'b1;
                  fault_q  <= mmu_rsp_fault;
               end
               if (pair_done && fault_now) trap_q <= TRAP_PROT;
            end
            default: ;
         endcase
      end
   end

   assign req_ready     = (state == SEQ_IDLE);
   assign mem_lock      = (state == SEQ_READ) || (state == SEQ_WRITE);
   assign mem_req_valid = ((state == SEQ_READ) && !rd_done) || (state == SEQ_WRITE);
   assign mem_req_write = (state == SEQ_WRITE);
   assign mmu_chk_valid = (state == SEQ_READ) && !chk_done;
   assign mmu_chk_write = mmu_chk_valid;   // read phase is checked as a store
   assign rsp_valid     = (state == SEQ_RESP);
   assign rsp_trap      = trap_q;

   // R10: the write only starts once both answers are in and clean.
   assert_write_after_clean_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (chk_done && rd_done && !fault_q));

   // R5: each permission query during the pair is typed as a store and is under lock.
   assert_query_as_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mmu_chk_valid |-> (mmu_chk_write && mem_lock && !mem_req_write));

   // R8: lock begins with the read request.
   assert_lock_opens_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_lock) |-> (mem_req_valid && !mem_req_write));

   // R8: no memory request outside the lock.
   assert_request_under_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_lock);

   // R9: one-cycle response pulse.
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7: an alignment trap comes straight from idle, so no access was made.
   assert_align_skips_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap == TRAP_ALIGN) |-> ($past(state) == SEQ_IDLE));

   // R6: a protection trap follows a faulting answer.
   assert_prot_from_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap == TRAP_PROT) |-> (chk_done && fault_q));

endmodule

// File: rtl/atomic_rmw_seq.sv
module atomic_rmw_seq
   import atomic_rmw_pkg::*;
#(
   parameter int         AW        = 32,
   parameter int         DW        = 32,
   parameter logic [7:0] SET_VALUE = 8'hFF,
   localparam int        LANES     = DW / 8,
   localparam int        OFS_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_op,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_src,
   output logic             mmu_chk_valid,
   output logic             mmu_chk_write,
   output logic [AW-1:0]    mmu_chk_addr,
   input  logic             mmu_rsp_valid,
   input  logic             mmu_rsp_fault,
   output logic             mem_req_valid,
   output logic             mem_req_write,
   output logic             mem_lock,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   output logic [LANES-1:0] mem_be,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             rsp_valid,
   output logic [1:0]       rsp_trap_code,
   output logic             rsp_rd_we,
   output logic [DW-1:0]    rsp_rdata
);

   if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
      $error("atomic_rmw_seq: DW must be a multiple of 8 and at least 16");
   end
   if (AW <= OFS_W) begin : g_bad_aw
      $error("atomic_rmw_seq: AW too small for the byte offset");
   end
   if ((1 << OFS_W) != LANES) begin : g_bad_lanes
      $error("atomic_rmw_seq: lane count must be a power of two");
   end

   logic          op_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] src_q, old_q;
   trap_e         trap_w;
   logic [DW-1:0] lane_wdata, lane_result;
   logic [LANES-1:0] lane_be;

   atomic_rmw_ctrl #(.AW(AW), .DW(DW), .OFS_W(OFS_W)) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_op        (req_op),
      .req_addr      (req_addr),
      .req_src       (req_src),
      .mmu_chk_valid (mmu_chk_valid),
      .mmu_chk_write (mmu_chk_write),
      .mmu_rsp_valid (mmu_rsp_valid),
      .mmu_rsp_fault (mmu_rsp_fault),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .mem_lock      (mem_lock),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata),
      .rsp_valid     (rsp_valid),
      .rsp_trap      (trap_w),
      .op_q          (op_q),
      .addr_q        (addr_q),
      .src_q         (src_q),
      .old_q         (old_q)
   );

   atomic_rmw_lanes #(.DW(DW), .SET_VALUE(SET_VALUE)) i_lanes (
      .op_byte  (op_q == OP_SET_BYTE),
      .offset   (addr_q[OFS_W-1:0]),
      .src      (src_q),
      .old_word (old_q),
      .wr_data  (lane_wdata),
      .wr_be    (lane_be),
      .result   (lane_result)
   );

   assign mmu_chk_addr  = addr_q;
   assign mem_addr      = {addr_q[AW-1:OFS_W], {OFS_W{1'b0}}};
   assign mem_wdata     = mem_req_write ? lane_wdata : '0;
   assign mem_be        = mem_req_write ? lane_be : '1;
   assign rsp_trap_code = trap_w;
   assign rsp_rd_we     = rsp_valid && (trap_w == TRAP_NONE);
   assign rsp_rdata     = rsp_rd_we ? lane_result : '0;

   // R6: a trapped response never writes the destination register.
   assert_trap_blocks_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_trap_code != 2'd0) |-> (!rsp_rd_we && rsp_rdata == '0));

   // R3: a test-and-set write touches exactly one byte lane.
   assert_set_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && op_q == OP_SET_BYTE) |-> ($countones(mem_be) == 1));

   // R5: the read phase fetches the whole word.
   assert_read_full_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (mem_be == '1));

endmodule

// File: tb/test_atomic_rmw_seq.sv
`timescale 1ns/1ps
module test_atomic_rmw_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready, req_op = 1'b0;
   logic [31:0] req_addr = '0, req_src = '0;
   logic        mmu_chk_valid, mmu_chk_write;
   logic [31:0] mmu_chk_addr;
   logic        mmu_rsp_valid = 1'b0, mmu_rsp_fault = 1'b0;
   logic        mem_req_valid, mem_req_write, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid, rsp_rd_we;
   logic [1:0]  rsp_trap_code;
   logic [31:0] rsp_rdata;

   always #2.5 clk = ~clk;

   atomic_rmw_seq i_atomic_rmw_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_src(req_src),
      .mmu_chk_valid(mmu_chk_valid), .mmu_chk_write(mmu_chk_write),
      .mmu_chk_addr(mmu_chk_addr), .mmu_rsp_valid(mmu_rsp_valid),
      .mmu_rsp_fault(mmu_rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_trap_code(rsp_trap_code),
      .rsp_rd_we(rsp_rd_we), .rsp_rdata(rsp_rdata)
   );

   int n_tests = 0, n_fail = 0;
   logic [31:0] mem     [0:63];   // memory behind the port
   logic [31:0] ref_mem [0:63];   // expected contents
   int m_lat = 0, k_lat = 0;
   int m_cnt = 0, k_cnt = 0;
   int n_rd = 0, n_wr = 0, n_chk = 0, n_lock_rise = 0;
   logic prev_lock = 1'b0;
   logic finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Memory responder: acknowledges after m_lat cycles, writes honour byte enables.
   initial forever begin
      @(negedge clk);
      if (mem_ack) begin
         mem_ack = 1'b0;
         m_cnt   = 0;
      end else if (mem_req_valid) begin
         if (m_cnt >= m_lat) begin
            mem_ack = 1'b1;
            if (mem_req_write) begin
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
               n_wr++;
            end else begin
               mem_rdata = mem[mem_addr[7:2]];
               n_rd++;
            end
         end else m_cnt++;
      end
   end

   // MMU responder: pages with address bit 8 set are read-only, so a store query faults.
   initial forever begin
      @(negedge clk);
      if (mmu_rsp_valid) begin
         mmu_rsp_valid = 1'b0;
         mmu_rsp_fault = 1'b0;
         k_cnt = 0;
      end else if (mmu_chk_valid) begin
         if (k_cnt >= k_lat) begin
            mmu_rsp_valid = 1'b1;
            mmu_rsp_fault = mmu_chk_write & mmu_chk_addr[8];
            n_chk++;
         end else k_cnt++;
      end
   end

   // Per-cycle invariants against the model's view of the ports.
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         check(!mem_req_valid || mem_lock, "R8", "request outside lock", {31'd0, mem_lock}, 32'd1);
         check(!mmu_chk_valid || mmu_chk_write, "R5", "query not typed as store",
               {31'd0, mmu_chk_write}, 32'd1);
         check(!(mem_req_valid && !mem_req_write) || mem_be == 4'hF, "R5", "read byte enables",
               {28'd0, mem_be}, 32'hF);
         check(!mem_lock || !req_ready, "R9", "ready while busy", {31'd0, req_ready}, 32'd0);
         if (mem_lock && !prev_lock) n_lock_rise++;
         prev_lock = mem_lock;
      end
   end

   task automatic run_op(input bit op, input logic [31:0] addr, input logic [31:0] src,
                         input int mlat, input int klat, input string req);
      int idx = int'(addr[7:2]);
      int ofs = int'(addr[1:0]);
      logic [31:0] old = ref_mem[idx];
      logic [1:0]  e_trap;
      logic [31:0] e_data;
      int wait_n = 0;
      int e_acc;
      if (op == 1'b0 && ofs != 0) begin
         e_trap = 2'd2; e_data = '0; e_acc = 0;
      end else if (addr[8]) begin
         e_trap = 2'd1; e_data = '0; e_acc = 1;
      end else begin
         e_trap = 2'd0; e_acc = 2;
         if (op == 1'b0) begin
            e_data = old;
            ref_mem[idx] = src;
         end else begin
            e_data = {24'd0, old[31-8*ofs -: 8]};
            ref_mem[idx][31-8*ofs -: 8] = 8'hFF;
         end
      end
      m_lat = mlat; k_lat = klat;
      n_rd = 0; n_wr = 0; n_chk = 0; n_lock_rise = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_src = src;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && wait_n < 200) begin
         @(negedge clk);
         wait_n++;
      end
      check(rsp_valid, req, "response seen", {31'd0, rsp_valid}, 32'd1);
      check(rsp_trap_code == e_trap, req, "trap code", {30'd0, rsp_trap_code}, {30'd0, e_trap});
      check(rsp_rd_we == (e_trap == 2'd0), req, "writeback", {31'd0, rsp_rd_we},
            {31'd0, e_trap == 2'd0});
      check(rsp_rdata == e_data, req, "old value", rsp_rdata, e_data);
      @(negedge clk);
      check(!rsp_valid, "R9", "pulse width", {31'd0, rsp_valid}, 32'd0);
      check(!mem_lock && req_ready, "R8", "lock released", {31'd0, mem_lock}, 32'd0);
      check(n_wr == (e_acc == 2 ? 1 : 0), req, "write count", n_wr, (e_acc == 2) ? 1 : 0);
      check(n_rd == (e_acc > 0 ? 1 : 0), req, "read count", n_rd, (e_acc > 0) ? 1 : 0);
      check(n_chk == (e_acc > 0 ? 1 : 0), req, "query count", n_chk, (e_acc > 0) ? 1 : 0);
      check(n_lock_rise == (e_acc > 0 ? 1 : 0), "R8", "lock intervals", n_lock_rise,
            (e_acc > 0) ? 1 : 0);
      check(mem[idx] == ref_mem[idx], req, "memory word", mem[idx], ref_mem[idx]);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]     = (i * 32'h0101_0101) ^ 32'hA5C3_0F1E;
         ref_mem[i] = (i * 32'h0101_0101) ^ 32'hA5C3_0F1E;
      end
      repeat (3) @(negedge clk);
      check(req_ready && !mem_req_valid && !mmu_chk_valid && !mem_lock && !rsp_valid,
            "R1", "state in reset", {27'd0, req_ready, mem_req_valid, mmu_chk_valid, mem_lock, rsp_valid},
            32'h10);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(req_ready && !mem_req_valid && !mmu_chk_valid && !mem_lock && !rsp_valid,
            "R1", "idle after reset", {27'd0, req_ready, mem_req_valid, mmu_chk_valid, mem_lock, rsp_valid},
            32'h10);

      run_op(1'b0, 32'h0000_0010, 32'hDEAD_BEEF, 1, 1, "R2");
      run_op(1'b0, 32'h0000_0010, 32'h1234_5678, 0, 0, "R2");   // returns DEADBEEF
      for (int k = 0; k < 4; k++)
         run_op(1'b1, 32'h0000_0020 + k, 32'h0, 1, 0, "R4");
      run_op(1'b1, 32'h0000_0022, 32'h0, 0, 1, "R3");            // already set: old FF
      run_op(1'b1, 32'h0000_0031, 32'h0, 2, 2, "R3");
      run_op(1'b0, 32'h0000_0104, 32'h5555_AAAA, 2, 2, "R6");    // fault with read ack same cycle
      run_op(1'b0, 32'h0000_0108, 32'h5555_AAAA, 3, 0, "R10");   // fault before read ack
      run_op(1'b0, 32'h0000_010C, 32'h5555_AAAA, 0, 4, "R10");   // fault after read ack
      run_op(1'b1, 32'h0000_0121, 32'h0, 1, 1, "R6");
      run_op(1'b0, 32'h0000_0012, 32'hFFFF_0000, 0, 0, "R7");
      run_op(1'b0, 32'h0000_0013, 32'hFFFF_0000, 0, 0, "R7");
      run_op(1'b1, 32'h0000_0043, 32'h0, 0, 0, "R7");            // byte op at odd offset is fine
      run_op(1'b0, 32'h0000_0050, 32'h0BAD_F00D, 0, 3, "R10");
      run_op(1'b0, 32'h0000_0054, 32'h0BAD_F00D, 3, 0, "R10");
      for (int i = 0; i < 64; i++)
         if (mem[i] != ref_mem[i]) check(1'b0, "R6", "final memory", mem[i], ref_mem[i]);
      check(1'b1, "R2", "final memory scan", 32'd0, 32'd0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule